// File: doc/BRIEF.md
# Per-Branch Local History Direction Predictor

This block predicts whether a conditional branch will be taken. It uses two tables. The first table holds one short outcome history for each group of branches that share the same low address bits. The second table holds 2-bit saturating counters. A prediction reads the history that the branch address selects. It XORs that history with the address bits to pick a counter, and it reports taken when the counter sits in its upper half. Because each branch group keeps its own history, a branch with a repeating pattern, such as a loop exit, learns that pattern without being disturbed by unrelated branches.

The fetch side drives `pred_pc_i`, which carries the instruction address with its alignment bits already dropped. It gets `pred_taken_o` back in the same cycle. When the branch resolves, the execute side presents the same address bits and the real outcome on the update port. The counter addressed by the history as it stood before this branch is trained first. The outcome is then shifted into that branch's history register. Both changes take effect at the next clock edge.

Top module: `local_hist_pred`

## Requirements
- R1: After reset every history register holds zero and every counter holds 01 (weakly not-taken), so `pred_taken_o` is 0 for every address until the first update.
- R2: The history register used for an address is the one numbered by the address bits [IDX_W-1:0].
- R3: The counter index is the selected history, zero-extended to CIDX_W = max(HIST_W, IDX_W) bits, XORed with all CIDX_W address bits.
- R4: An update moves the selected counter up by one when the outcome is taken (1) and down by one when it is not-taken (0). It saturates at 11 and at 00.
- R5: `pred_taken_o` is 1 exactly when the selected counter holds 10 or 11.
- R6: On update, the selected history register shifts left by one place, the outcome enters bit 0 (1 = taken), and the oldest bit is dropped.
- R7: The counter trained by an update is the one indexed by the history value before that same update shifts it.
- R8: While `upd_valid_i` is 0, no history register and no counter changes, whatever the values on `upd_pc_i` and `upd_taken_i`.
- R9: Prediction is combinational from the registered state. A prediction in the same cycle as an update sees the state from before that update, and the new state is visible from the next cycle on.
- R10: An update changes only the history register of its own address group. Addresses that map to other history registers keep their histories.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_pc_i | input | CIDX_W | Index bits of the address being predicted |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| upd_valid_i | input | 1 | A resolved branch is presented for training |
| upd_pc_i | input | CIDX_W | Index bits of the resolved branch address |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
The hardest state to reach from the ports is a counter pinned at either saturation limit. Every update also moves the history, so the counter being trained moves to a new index each time. The stimulus therefore repeats one outcome on one address until its history fills with all ones or all zeros. After that, the same counter is hit again and again, and it is driven past both ends. Aliasing between address groups and same-cycle predict-and-update on one address are both forced on purpose. A long random phase then compares every cycle against a behavioural model.

// File: rtl/lhp_pkg.sv
`timescale 1ns/1ps
package lhp_pkg;

    // Two-bit direction counter states, ordered so that +1 moves toward taken.
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    localparam ctr_e CTR_RESET = CTR_WEAK_NT;

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Saturating step of a direction counter.
    function automatic ctr_e ctr_train(ctr_e cur, logic taken);
        ctr_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = ctr_e'(cur + 2'd1);
        end else begin
            if (cur != CTR_STRONG_NT) nxt = ctr_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(ctr_e c);
        return c[1];
    endfunction

endpackage

// File: rtl/lhp_index.sv
`timescale 1ns/1ps
module lhp_index #(
    parameter int IDX_W  = 4,
    parameter int HIST_W = 6,
    parameter int CIDX_W = 6
) (
    input  logic [CIDX_W-1:0]                   pc_i,
    input  logic [(1<<IDX_W)-1:0][HIST_W-1:0]   hist_all_i,
    output logic [CIDX_W-1:0]                   cidx_o
);

    logic [IDX_W-1:0]  hsel;
    logic [HIST_W-1:0] hist_sel;

    assign hsel     = pc_i[IDX_W-1:0];
    assign hist_sel = hist_all_i[hsel];

    // Zero-extend the history to the counter index width, then fold in the address.
    always_comb begin
        cidx_o = pc_i ^ CIDX_W'(hist_sel);
    end

endmodule

// File: rtl/lhp_hist_table.sv
`timescale 1ns/1ps
module lhp_hist_table #(
    parameter int IDX_W  = 4,
    parameter int HIST_W = 6
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                wr_en_i,
    input  logic [IDX_W-1:0]                    wr_idx_i,
    input  logic                                wr_taken_i,
    output logic [(1<<IDX_W)-1:0][HIST_W-1:0]   hist_all_o
);

    localparam int HIST_N = 1 << IDX_W;

    typedef logic [HIST_W-1:0] hist_t;

    typedef struct packed {
        hist_t [HIST_N-1:0] regs;
    } hist_state_t;

    hist_state_t st_d, st_q;
    hist_t       shifted;

    // Newest outcome enters bit 0; a one-bit history simply holds the last outcome.
    generate
        if (HIST_W == 1) begin : g_single
            assign shifted = wr_taken_i;
        end else begin : g_multi
            assign shifted = {st_q.regs[wr_idx_i][HIST_W-2:0], wr_taken_i};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.regs[wr_idx_i] = shifted;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist_all_o = st_q.regs;

endmodule

// File: rtl/lhp_ctr_table.sv
`timescale 1ns/1ps
module lhp_ctr_table
    import lhp_pkg::*;
#(
    parameter int CIDX_W = 6
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             wr_en_i,
    input  logic [CIDX_W-1:0]                wr_idx_i,
    input  logic                             wr_taken_i,
    output logic [(1<<CIDX_W)-1:0][1:0]      ctr_all_o
);

    localparam int CNT_N = 1 << CIDX_W;

    typedef struct packed {
        ctr_e [CNT_N-1:0] cells;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    ctr_e       cur;

    assign cur = st_q.cells[wr_idx_i];

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.cells[wr_idx_i] = ctr_train(cur, wr_taken_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < CNT_N; i++) begin
                st_q.cells[i] <= CTR_RESET;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign ctr_all_o = st_q.cells;

endmodule

// File: rtl/local_hist_pred.sv
`timescale 1ns/1ps
module local_hist_pred
    import lhp_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int HIST_W = 6
) (
    input  logic                                        clk_i,
    input  logic                                        rst_ni,
    input  logic [lhp_pkg::max_u(HIST_W, IDX_W)-1:0]    pred_pc_i,
    output logic                                        pred_taken_o,
    input  logic                                        upd_valid_i,
    input  logic [lhp_pkg::max_u(HIST_W, IDX_W)-1:0]    upd_pc_i,
    input  logic                                        upd_taken_i
);

    localparam int CIDX_W = lhp_pkg::max_u(HIST_W, IDX_W);
    localparam int HIST_N = 1 << IDX_W;
    localparam int CNT_N  = 1 << CIDX_W;

    logic [HIST_N-1:0][HIST_W-1:0] hist_all;
    logic [CNT_N-1:0][1:0]         ctr_all;
    logic [CIDX_W-1:0]             pred_cidx;
    logic [CIDX_W-1:0]             upd_cidx;
    logic [IDX_W-1:0]              upd_hidx;

    // Both index paths read the registered history, so training uses the pre-shift value.
    lhp_index #(.IDX_W(IDX_W), .HIST_W(HIST_W), .CIDX_W(CIDX_W)) u_pred_idx (
        .pc_i       (pred_pc_i),
        .hist_all_i (hist_all),
        .cidx_o     (pred_cidx)
    );

    lhp_index #(.IDX_W(IDX_W), .HIST_W(HIST_W), .CIDX_W(CIDX_W)) u_upd_idx (
        .pc_i       (upd_pc_i),
        .hist_all_i (hist_all),
        .cidx_o     (upd_cidx)
    );

    assign upd_hidx = upd_pc_i[IDX_W-1:0];

    lhp_hist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_hist (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (upd_valid_i),
        .wr_idx_i   (upd_hidx),
        .wr_taken_i (upd_taken_i),
        .hist_all_o (hist_all)
    );

    lhp_ctr_table #(.CIDX_W(CIDX_W)) u_ctr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (upd_valid_i),
        .wr_idx_i   (upd_cidx),
        .wr_taken_i (upd_taken_i),
        .ctr_all_o  (ctr_all)
    );

    assign pred_taken_o = ctr_says_taken(ctr_e'(ctr_all[pred_cidx]));

endmodule

// File: rtl/lhp_checker.sv
`timescale 1ns/1ps
module lhp_checker #(
    parameter int IDX_W  = 4,
    parameter int HIST_W = 6,
    parameter int CIDX_W = 6
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic [CIDX_W-1:0]                   pred_pc_i,
    input  logic                                pred_taken_i,
    input  logic                                upd_valid_i,
    input  logic [CIDX_W-1:0]                   upd_pc_i,
    input  logic                                upd_taken_i,
    input  logic [(1<<IDX_W)-1:0][HIST_W-1:0]   hist_all_i,
    input  logic [(1<<CIDX_W)-1:0][1:0]         ctr_all_i,
    input  logic [CIDX_W-1:0]                   upd_cidx_i
);

    logic              seen_upd_q;
    logic [IDX_W-1:0]  p_h, u_h;
    logic [CIDX_W-1:0] p_c, u_c;
    logic [1:0]        u_old, u_exp;
    logic [HIST_W-1:0] h_old, h_exp;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seen_upd_q <= 1'b0;
        else if (upd_valid_i) seen_upd_q <= 1'b1;
    end

    assign p_h   = pred_pc_i[IDX_W-1:0];
    assign u_h   = upd_pc_i[IDX_W-1:0];
    assign p_c   = pred_pc_i ^ CIDX_W'(hist_all_i[p_h]);
    assign u_c   = upd_pc_i ^ CIDX_W'(hist_all_i[u_h]);
    assign u_old = ctr_all_i[u_c];
    assign h_old = hist_all_i[u_h];
    assign h_exp = HIST_W'({h_old, upd_taken_i});

    always_comb begin
        if (upd_taken_i) u_exp = (u_old == 2'b11) ? 2'b11 : u_old + 2'b01;
        else             u_exp = (u_old == 2'b00) ? 2'b00 : u_old - 2'b01;
    end

    a_r1_reset_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !seen_upd_q |-> !pred_taken_i);

    a_r5_pred_from_ctr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pred_taken_i == ctr_all_i[p_c][1]);

    a_r7_pre_update_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_valid_i |-> (upd_cidx_i == u_c));

    a_r4_ctr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_valid_i |=> (ctr_all_i[$past(u_c)] == $past(u_exp)));

    a_r6_hist_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_valid_i |=> (hist_all_i[$past(u_h)] == $past(h_exp)));

    a_r8_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_valid_i |=> ($stable(hist_all_i) && $stable(ctr_all_i)));

endmodule

bind local_hist_pred lhp_checker #(
    .IDX_W  (IDX_W),
    .HIST_W (HIST_W),
    .CIDX_W (CIDX_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pred_pc_i    (pred_pc_i),
    .pred_taken_i (pred_taken_o),
    .upd_valid_i  (upd_valid_i),
    .upd_pc_i     (upd_pc_i),
    .upd_taken_i  (upd_taken_i),
    .hist_all_i   (hist_all),
    .ctr_all_i    (ctr_all),
    .upd_cidx_i   (upd_cidx)
);

// File: tb/local_hist_pred_tb_top.sv
`timescale 1ns/1ps
module local_hist_pred_tb_top;

    localparam int IDX_W  = 4;
    localparam int HIST_W = 6;
    localparam int CIDX_W = (HIST_W > IDX_W) ? HIST_W : IDX_W;
    localparam int HIST_N = 1 << IDX_W;
    localparam int CNT_N  = 1 << CIDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CIDX_W-1:0] pred_pc = '0;
    logic [CIDX_W-1:0] upd_pc = '0;
    logic              upd_valid = 1'b0;
    logic              upd_taken = 1'b0;
    logic              pred_taken;

    int  hist_m [HIST_N];
    int  ctr_m  [CNT_N];
    int  n_cmp = 0;
    int  n_bad = 0;

    always #10 clk = ~clk;

    local_hist_pred #(.IDX_W(IDX_W), .HIST_W(HIST_W)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .pred_pc_i    (pred_pc),
        .pred_taken_o (pred_taken),
        .upd_valid_i  (upd_valid),
        .upd_pc_i     (upd_pc),
        .upd_taken_i  (upd_taken)
    );

    function automatic void model_reset();
        foreach (hist_m[i]) hist_m[i] = 0;
        foreach (ctr_m[i])  ctr_m[i]  = 1;
    endfunction

    function automatic bit model_pred(int pc);
        int h;
        int c;
        h = pc % HIST_N;
        c = (hist_m[h] ^ pc) % CNT_N;
        return ctr_m[c] >= 2;
    endfunction

    function automatic void model_update(int pc, bit t);
        int h;
        int c;
        h = pc % HIST_N;
        c = (hist_m[h] ^ pc) % CNT_N;
        if (t) ctr_m[c] = (ctr_m[c] == 3) ? 3 : ctr_m[c] + 1;
        else   ctr_m[c] = (ctr_m[c] == 0) ? 0 : ctr_m[c] - 1;
        hist_m[h] = (hist_m[h] * 2 + (t ? 1 : 0)) % (1 << HIST_W);
    endfunction

    task automatic compare(string req, int pc, logic got, bit exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: pc=%0d pred_taken=%0b expected %0b", req, pc, got, exp);
        end
    endtask

    // One cycle: drive between edges, check against the model, then advance the model.
    task automatic step(int ppc, bit v, int upc, bit t, string req);
        @(negedge clk);
        pred_pc   = CIDX_W'(ppc);
        upd_valid = v;
        upd_pc    = CIDX_W'(upc);
        upd_taken = t;
        #2;
        compare(req, ppc, pred_taken, model_pred(ppc));
        if (v) model_update(upc % CNT_N, t);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        upd_valid = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        do_reset();

        // R1: every address predicts not-taken straight after reset
        for (int p = 0; p < CNT_N; p++) step(p, 1'b0, 0, 1'b0, "R1");

        // R4 R6 R9: drive one address taken until its history is all ones, then past saturation
        for (int i = 0; i < 14; i++) step(5, 1'b1, 5, 1'b1, "R9");
        for (int i = 0; i < 4; i++)  step(5, 1'b0, 0, 1'b0, "R4");
        // R4: drive it not-taken until history is all zeros and counter hits 00
        for (int i = 0; i < 16; i++) step(5, 1'b1, 5, 1'b0, "R4");
        for (int i = 0; i < 4; i++)  step(5, 1'b0, 0, 1'b0, "R6");

        // R5: alternating pattern walks counters through the weak states
        for (int i = 0; i < 24; i++) step(9, 1'b1, 9, (i % 2) == 0, "R5");
        for (int i = 0; i < 8; i++)  step(9 + 16 * (i % 4), 1'b0, 0, 1'b0, "R5");

        // R8: update port toggling with valid low must not change anything
        for (int i = 0; i < 40; i++) step(i % CNT_N, 1'b0, $urandom % CNT_N, $urandom % 2, "R8");

        // R10 R2: train address 3, probe aliases sharing its history and neighbours that do not
        for (int i = 0; i < 10; i++) step(19, 1'b1, 3, 1'b1, "R10");
        for (int p = 0; p < HIST_N; p++) step(p, 1'b0, 0, 1'b0, "R2");
        for (int p = 3; p < CNT_N; p += HIST_N) step(p, 1'b0, 0, 1'b0, "R2");

        // R3: few addresses with random outcomes, full sweep of predictions
        for (int i = 0; i < 600; i++) step($urandom % CNT_N, 1'b1, $urandom % 8, $urandom % 2, "R3");

        // R7: long random mix of predict and update traffic
        for (int i = 0; i < 3000; i++)
            step($urandom % CNT_N, ($urandom % 4) != 0, $urandom % CNT_N, $urandom % 2, "R7");

        // R1: reset in the middle of a trained state
        do_reset();
        for (int p = 0; p < CNT_N; p++) step(p, 1'b0, 0, 1'b0, "R1");

        summary();
        $finish;
    end

endmodule